// File: doc/BRIEF.md
# Peripheral DMA Request Router

This block sits between a set of peripheral request lines and a multi-channel DMA engine. Each request line has its own routing entry, written over a 32-bit register bus. An entry names a channel and carries an enable flag. The router passes every request line through a two-stage synchroniser. It then combines the enabled lines into one request level per channel and drives that level to the channel's transfer logic.

The router also watches each enabled line for edges. A rising edge sets the channel's request-arrived flag. A falling edge produces a one-cycle end-of-receive pulse for that channel. The channel status logic uses both signals to stop or resume a transfer. Arbitration and data movement belong to the DMA engine and are not part of this block.

Top module: `dreq_router`

## Requirements
- R1: After reset every routing entry reads as zero (disabled), and all channel request levels, request-arrived flags and end-of-receive pulses are low.
- R2: A routing entry reads back as 32 bits with the enable flag in bit 7 and the channel index in bits 4:0. All other bits read zero, whatever value was written to them.
- R3: The entry for request n (n = 0..63) sits at byte offset 0x100 + 4n. The entry for request n (n = 64..74) sits at byte offset 0x1100 + 4(n - 64).
- R4: A request whose entry has the enable flag clear has no effect on any channel level, flag or pulse.
- R5: Channel c's request level is the OR of all synchronised requests routed to c. A change on a request input that is stable at clock edge k appears on the output after edge k+2.
- R6: A rising edge on any request routed to channel c sets c's request-arrived flag. A falling edge on a routed request clears the flag, unless another routed request rises in the same cycle; in that case the flag is set.
- R7: A falling edge on any request routed to channel c makes c's end-of-receive output high for exactly that one cycle, with the same latency as R5.
- R8: A write that sets the enable flag with a channel index at or above the channel count stores the index with the enable flag cleared. The entry reads back disabled and routes nothing.
- R9: Byte offsets 0xE0, 0xE4 and 0xE8 read as zero, and writes to them change no routing entry. Every other unmapped offset also reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_in | input | NUM_REQ (75) | Asynchronous peripheral request lines |
| ch_req | output | NUM_CH (16) | Per-channel combined request level |
| ch_ras | output | NUM_CH (16) | Per-channel request-arrived flag |
| ch_eor | output | NUM_CH (16) | Per-channel end-of-receive pulse |

## Verification
The case that needs the most care is two requests routed to the same channel moving in opposite directions in the same cycle. One line rises while the other falls, so the flag-set and flag-clear rules of R6 collide while R7 also fires. The bench routes two requests, one from each address window, to one channel. It drives the crossing on a single falling clock edge. Three edges later it expects the level to stay high, the flag to be set and the end-of-receive pulse to appear, and a reference model checks all three outputs on every cycle.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    localparam logic [7:0]  WIN_LO_PAGE = 8'h01;
    localparam logic [7:0]  WIN_HI_PAGE = 8'h11;
    localparam int          WIN_LO_N    = 64;
    localparam logic [15:0] STAT_A      = 16'h00E0;
    localparam logic [15:0] STAT_B      = 16'h00E4;
    localparam logic [15:0] STAT_C      = 16'h00E8;

    typedef struct packed {
        logic       vld;
        logic [4:0] ch;
    } map_ent_t;

    typedef struct packed {
        logic       hit;
        logic [6:0] idx;
    } map_dec_t;

    function automatic map_dec_t map_decode(input logic [15:0] a, input int nreq);
        map_dec_t d;
        logic [7:0] ix;
        logic       win;
        d   = '0;
        ix  = '0;
        win = 1'b0;
        if (a[1:0] == 2'b00) begin
            if (a[15:8] == WIN_LO_PAGE) begin
                ix  = {2'b00, a[7:2]};
                win = 1'b1;
            end else if (a[15:8] == WIN_HI_PAGE) begin
                ix  = 8'(WIN_LO_N) + {2'b00, a[7:2]};
                win = 1'b1;
            end
        end
        d.hit = win && (int'(ix) < nreq);
        d.idx = ix[6:0];
        return d;
    endfunction

    function automatic logic is_status(input logic [15:0] a);
        return (a == STAT_A) || (a == STAT_B) || (a == STAT_C);
    endfunction

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int N = 75
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    output logic [N-1:0] req_s,
    output logic [N-1:0] req_p
);

    typedef struct packed {
        logic [N-1:0] st1;
        logic [N-1:0] st2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.st1  = req_in;
        sy_d.st2  = sy_q.st1;
        sy_d.prev = sy_q.st2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign req_s = sy_q.st2;
    assign req_p = sy_q.prev;

    logic [1:0] alive_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               alive_q <= '0;
        else if (alive_q != 2'd3) alive_q <= alive_q + 2'd1;
    end

    // R5: two-stage synchroniser delay
    p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alive_q == 2'd3) |-> (req_s == $past(req_in, 2)));

endmodule

// File: rtl/dreq_mapregs.sv
module dreq_mapregs
    import dreq_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [15:0]               addr,
    input  logic [31:0]               wdata,
    output logic [31:0]               rdata,
    output map_ent_t [NUM_REQ-1:0]    map_o
);

    localparam logic [5:0] CH_LIM = 6'(NUM_CH);

    typedef struct packed {
        map_ent_t [NUM_REQ-1:0] ent;
    } tbl_t;

    tbl_t     tb_d, tb_q;
    map_dec_t dec;
    map_ent_t sel;

    always_comb begin
        dec  = map_decode(addr, NUM_REQ);
        tb_d = tb_q;
        if (wr_en && dec.hit) begin
            tb_d.ent[dec.idx].ch  = wdata[4:0];
            tb_d.ent[dec.idx].vld = wdata[7] && ({1'b0, wdata[4:0]} < CH_LIM);
        end
        sel   = tb_q.ent[dec.idx];
        rdata = dec.hit ? {24'd0, sel.vld, 2'b00, sel.ch} : 32'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign map_o = tb_q.ent;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
        // R8: an enabled entry always names an existing channel
        p_vld_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
            tb_q.ent[i].vld |-> ({1'b0, tb_q.ent[i].ch} < CH_LIM));
    end

    // R9: status offsets read zero
    p_status_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_status(addr) |-> (rdata == 32'd0));

endmodule

// File: rtl/dreq_route.sv
module dreq_route
    import dreq_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_REQ-1:0]     req_s,
    input  logic [NUM_REQ-1:0]     req_p,
    input  map_ent_t [NUM_REQ-1:0] map_i,
    output logic [NUM_CH-1:0]      ch_req,
    output logic [NUM_CH-1:0]      ch_ras,
    output logic [NUM_CH-1:0]      ch_eor
);

    typedef struct packed {
        logic [NUM_CH-1:0] lvl;
        logic [NUM_CH-1:0] ras;
        logic [NUM_CH-1:0] eor;
    } rt_t;

    rt_t rt_d, rt_q;
    logic [NUM_CH-1:0] rise, fall;

    always_comb begin
        rt_d = rt_q;
        rise = '0;
        fall = '0;
        rt_d.lvl = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int r = 0; r < NUM_REQ; r++) begin
                if (map_i[r].vld && (map_i[r].ch == 5'(c))) begin
                    rt_d.lvl[c] = rt_d.lvl[c] | req_s[r];
                    rise[c]     = rise[c] | (req_s[r] & ~req_p[r]);
                    fall[c]     = fall[c] | (~req_s[r] & req_p[r]);
                end
            end
            if (rise[c])      rt_d.ras[c] = 1'b1;
            else if (fall[c]) rt_d.ras[c] = 1'b0;
        end
        rt_d.eor = fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign ch_req = rt_q.lvl;
    assign ch_ras = rt_q.ras;
    assign ch_eor = rt_q.eor;

    // R5: no synchronised request last cycle means no channel level now
    p_level_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|req_s) |-> (ch_req == '0));

    // R7: an end-of-receive pulse needs a falling synchronised request
    p_eor_needs_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_eor) |-> $past(|(req_p & ~req_s)));

    // R6: a newly set flag needs a rising synchronised request
    p_ras_needs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ch_ras & ~$past(ch_ras))) |-> $past(|(req_s & ~req_p)));

endmodule

// File: rtl/dreq_router.sv
module dreq_router
    import dreq_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [15:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_REQ-1:0] req_in,
    output logic [NUM_CH-1:0]  ch_req,
    output logic [NUM_CH-1:0]  ch_ras,
    output logic [NUM_CH-1:0]  ch_eor
);

    logic [NUM_REQ-1:0]     req_s, req_p;
    map_ent_t [NUM_REQ-1:0] map_w;

    dreq_sync #(.N(NUM_REQ)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (req_in),
        .req_s  (req_s),
        .req_p  (req_p)
    );

    dreq_mapregs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .map_o  (map_w)
    );

    dreq_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_s  (req_s),
        .req_p  (req_p),
        .map_i  (map_w),
        .ch_req (ch_req),
        .ch_ras (ch_ras),
        .ch_eor (ch_eor)
    );

endmodule

// File: tb/tb_dreq_router.sv
module tb_dreq_router;

    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 75;
    localparam int NCH  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [15:0]     reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NREQ-1:0] req_in = '0;
    logic [NCH-1:0]  ch_req, ch_ras, ch_eor;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    dreq_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
        .ch_req(ch_req), .ch_ras(ch_ras), .ch_eor(ch_eor)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    bit              m_vld [NREQ];
    int              m_ch  [NREQ];
    logic [NREQ-1:0] hist[$];
    logic [NCH-1:0]  e_lvl, e_ras, e_eor;

    function automatic int ref_index(input logic [15:0] a);
        int v;
        v = int'(a);
        if (v % 4 != 0) return -1;
        if (v >= 'h100 && v < 'h200) return (v - 'h100) / 4;
        if (v >= 'h1100 && v < 'h1100 + 4 * (NREQ - 64)) return 64 + (v - 'h1100) / 4;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREQ; r++) begin m_vld[r] = 0; m_ch[r] = 0; end
            hist = {'0, '0, '0, '0};
            e_lvl = '0; e_ras = '0; e_eor = '0;
        end else begin
            logic [NREQ-1:0] s, p;
            int ix;
            hist.push_front(req_in);
            void'(hist.pop_back());
            s = hist[2];
            p = hist[3];
            for (int c = 0; c < NCH; c++) begin
                bit lv, ri, fa;
                lv = 0; ri = 0; fa = 0;
                for (int r = 0; r < NREQ; r++) begin
                    if (m_vld[r] && m_ch[r] == c) begin
                        if (s[r]) lv = 1;
                        if (s[r] && !p[r]) ri = 1;
                        if (!s[r] && p[r]) fa = 1;
                    end
                end
                e_lvl[c] = lv;
                e_eor[c] = fa;
                if (ri) e_ras[c] = 1'b1;
                else if (fa) e_ras[c] = 1'b0;
            end
            if (reg_wr) begin
                ix = ref_index(reg_addr);
                if (ix >= 0) begin
                    m_ch[ix]  = int'(reg_wdata[4:0]);
                    m_vld[ix] = reg_wdata[7] && (int'(reg_wdata[4:0]) < NCH);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 level", 32'(ch_req), 32'(e_lvl));
            chk("R6 flag",  32'(ch_ras), 32'(e_ras));
            chk("R7 pulse", 32'(ch_eor), 32'(e_eor));
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [15:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 20000) begin @(posedge clk); cyc++; end
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1: reset state
        chk("R1 level", 32'(ch_req), 32'd0);
        chk("R1 flag",  32'(ch_ras), 32'd0);
        chk("R1 pulse", 32'(ch_eor), 32'd0);
        rd("R1 entry 0", 16'h0100, 32'd0);
        rd("R1 entry 74", 16'h1128, 32'd0);

        // R2: field layout and ignored bits
        wr(16'h010C, 32'h0000_0082);
        rd("R2 readback", 16'h010C, 32'h82);
        wr(16'h010C, 32'hFFFF_FF62);
        rd("R2 junk bits", 16'h010C, 32'h02);
        wr(16'h010C, 32'h0000_0082);

        // R3: both windows
        wr(16'h1118, 32'h85);
        rd("R3 req70", 16'h1118, 32'h85);
        wr(16'h1100, 32'h8F);
        rd("R3 req64", 16'h1100, 32'h8F);
        rd("R3 req6 untouched", 16'h0118, 32'd0);
        rd("R3 beyond last", 16'h112C, 32'd0);

        // R5 latency and R6 flag set
        req_in[3] = 1'b1;
        step(2);
        chk("R5 not yet", 32'(ch_req[2]), 32'd0);
        step(1);
        chk("R5 level up", 32'(ch_req[2]), 32'd1);
        chk("R6 flag set", 32'(ch_ras[2]), 32'd1);
        step(2);

        // R7 pulse and R6 clear
        req_in[3] = 1'b0;
        step(3);
        chk("R7 pulse", 32'(ch_eor[2]), 32'd1);
        chk("R6 flag clear", 32'(ch_ras[2]), 32'd0);
        step(1);
        chk("R7 one cycle", 32'(ch_eor[2]), 32'd0);

        // R4: disabled and unrouted requests
        wr(16'h0128, 32'h05);
        req_in[10] = 1'b1; req_in[20] = 1'b1;
        step(3);
        chk("R4 level", 32'(ch_req), 32'd0);
        chk("R4 flag",  32'(ch_ras), 32'd0);
        req_in[10] = 1'b0; req_in[20] = 1'b0;
        step(3);
        chk("R4 pulse", 32'(ch_eor), 32'd0);

        // R5 OR of two requests on channel 2
        wr(16'h1118, 32'h82);
        req_in[3] = 1'b1; req_in[70] = 1'b1;
        step(3);
        chk("R5 or up", 32'(ch_req[2]), 32'd1);
        req_in[3] = 1'b0;
        step(3);
        chk("R5 or held", 32'(ch_req[2]), 32'd1);
        chk("R7 partial fall", 32'(ch_eor[2]), 32'd1);
        chk("R6 fall clears", 32'(ch_ras[2]), 32'd0);

        // R6/R7 crossing in one cycle
        req_in[3] = 1'b1; req_in[70] = 1'b0;
        step(3);
        chk("R6 rise wins", 32'(ch_ras[2]), 32'd1);
        chk("R7 crossing pulse", 32'(ch_eor[2]), 32'd1);
        chk("R5 crossing level", 32'(ch_req[2]), 32'd1);
        req_in[3] = 1'b0;
        step(4);

        // R3/R5 second window request on channel 15
        req_in[64] = 1'b1;
        step(3);
        chk("R3 req64 level", 32'(ch_req[15]), 32'd1);
        req_in[64] = 1'b0;
        step(4);

        // R8: out-of-range channel index
        wr(16'h0110, 32'h9F);
        rd("R8 ch31 disabled", 16'h0110, 32'h1F);
        wr(16'h0114, 32'h90);
        rd("R8 ch16 disabled", 16'h0114, 32'h10);
        req_in[4] = 1'b1; req_in[5] = 1'b1;
        step(3);
        chk("R8 no level", 32'(ch_req), 32'd0);
        req_in[4] = 1'b0; req_in[5] = 1'b0;
        step(3);

        // R9: status offsets
        wr(16'h00E0, 32'hFFFF_FFFF);
        wr(16'h00E4, 32'hFFFF_FFFF);
        rd("R9 status a", 16'h00E0, 32'd0);
        rd("R9 status b", 16'h00E4, 32'd0);
        rd("R9 status c", 16'h00E8, 32'd0);
        rd("R9 map kept", 16'h010C, 32'h82);
        rd("R9 map low kept", 16'h0100, 32'd0);
        rd("R9 other offset", 16'h0204, 32'd0);

        step(4);
        finish_run();
    end

endmodule